// File: doc/BRIEF.md
# Handshaked Run-State Controller

This block is the run-state control register of a serial bus master core. Software reaches it through a simple 32-bit register port. It holds a two-bit committed state (reset, run or pause) and a valid flag. A state write does not take effect at once. The valid flag drops, and a two-part handshake runs: a fixed number of bus-clock cycles, then a fixed number of core-clock ticks. When the handshake ends, the requested state is committed and the flag comes back up. Software polls the flag before it relies on the new state.

The committed state drives two outputs toward the data engine. `run_enable` lets the engine move data on the serial bus. `pause_hold` keeps the engine off the bus while its output queue is being filled. The core clock is modelled as a tick-enable input, so the whole block runs in one clock domain.

The block also handles the error flags that tie to state writes:
- a sticky flag for a state write that arrived while a handshake was still running;
- a pending bus-error condition that an accepted write of the reset state clears.

Top module: `runstate_ctrl`

## Requirements
- R1: After reset the committed state is reset (code 0) and `state_valid` is 1. `run_enable`, `pause_hold` and `bus_err_irq` are 0, and the error register reads 0.
- R2: A write to the state register (offset 0x0, code in bits [1:0]) with code 0, 1 or 3 while `state_valid` is 1 is accepted. `state_valid` reads 0 from the next cycle, and the committed state does not change until the handshake ends.
- R3: The handshake lasts `BUS_CYCLES` (default 3) clock cycles, then `CORE_TICKS` (default 3) cycles in which `core_tick` is high. With `core_tick` held high, the target state appears and `state_valid` rises on the sixth edge after the accepting edge. Without ticks the handshake stalls.
- R4: A state write with the unused code 2 is ignored: the state and `state_valid` keep their values.
- R5: A state write while `state_valid` is 0 is dropped, and the sticky busy-write flag (bit 0 of the error register at offset 0xC) is set. Writing 1 to that bit clears it.
- R6: Soft reset has two sources: writing 1 in bit 0 at offset 0x8, or a pulse on `srst_strobe`. On the next edge it forces state reset with `state_valid` 1, aborts any running handshake and clears both error flags. A write of 0 in bit 0 at offset 0x8 has no effect.
- R7: A `bus_err_evt` pulse sets the pending bus-error flag (error register bit 1, output `bus_err_irq`). The flag is cleared only by an accepted write of the reset code, or by soft reset. When a set and a clear arrive together, the set wins.
- R8: `run_enable` is 1 only while the committed state is run and `state_valid` is 1. `pause_hold` is 1 while the committed state is pause.
- R9: The state register reads the state in bits [1:0] and `state_valid` in bit 2. Bit 4 is the master-ready bit: it is 1 when `state_valid` is 1 and no bus error is pending.
- R10: A read of an unmapped offset (for example 0x4) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| srst_strobe | input | 1 | Soft-reset pulse |
| core_tick | input | 1 | One pulse per core-clock cycle |
| bus_err_evt | input | 1 | Bus-error event from the serial engine |
| state_out | output | 2 | Committed run state |
| state_valid | output | 1 | No handshake in progress |
| run_enable | output | 1 | Engine may run |
| pause_hold | output | 1 | Engine holds off the bus |
| bus_err_irq | output | 1 | Bus error pending |

## Verification
The assertions check, on every cycle, these local rules:
- valid drops after an accepted write;
- the state holds while the handshake runs;
- code 2 is ignored;
- the busy-write flag becomes sticky;
- soft reset forces the reset state;
- an accepted reset write clears the bus error;
- the bus phase count stays bounded, and the core phase stalls without a tick.

Only the bench scenarios show end-to-end behaviour: the exact six-edge commit latency, stalls under sparse or absent ticks, a soft reset that aborts a running handshake, and the register read layout. These are compared every cycle against a behavioural model built on countdown counters.

// File: rtl/rsc_pkg.sv
// Package: shared encodings for the run-state controller.
// Assumes: the state codes are fixed by the engine that decodes them.
package rsc_pkg;

    typedef enum logic [1:0] {
        RS_RESET  = 2'd0,
        RS_RUN    = 2'd1,
        RS_UNUSED = 2'd2,
        RS_PAUSE  = 2'd3
    } run_state_e;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_BUS  = 2'd1,
        HS_CORE = 2'd2
    } hs_phase_e;

    localparam int VALID_BIT    = 2;
    localparam int READY_BIT    = 4;
    localparam int ERR_BUSY_BIT = 0;
    localparam int ERR_BUS_BIT  = 1;

endpackage

// File: rtl/rsc_handshake_timer.sv
// Module: two-phase handshake timer. It first counts BUS_CYC clock cycles,
// then CORE_TICKS cycles in which core_tick is high, then pulses done.
// Assumes: start is only raised while the timer is idle; abort wins over start.
module rsc_handshake_timer
    import rsc_pkg::*;
#(
    parameter int BUS_CYC    = 3,
    parameter int CORE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic core_tick,
    output logic busy,
    output logic done
);

    localparam int MAXC = (BUS_CYC > CORE_TICKS) ? BUS_CYC : CORE_TICKS;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] BUS_LAST  = CW'(BUS_CYC - 1);
    localparam logic [CW-1:0] CORE_LAST = CW'(CORE_TICKS - 1);

    hs_phase_e     phase_q;
    logic [CW-1:0] cnt_q;

    // Purpose: step through the bus phase, then the tick-gated core phase.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            phase_q <= HS_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                HS_IDLE: begin
                    if (start) begin
                        phase_q <= HS_BUS;
                        cnt_q   <= '0;
                    end
                end
                HS_BUS: begin
                    if (cnt_q == BUS_LAST) begin
                        phase_q <= HS_CORE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                HS_CORE: begin
                    if (core_tick) begin
                        if (cnt_q == CORE_LAST) begin
                            phase_q <= HS_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    phase_q <= HS_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Purpose: report activity and the final-tick completion pulse.
    always_comb begin
        busy = (phase_q != HS_IDLE);
        done = (phase_q == HS_CORE) && core_tick && (cnt_q == CORE_LAST);
    end

    // R3: the bus-phase count never passes its limit.
    a_r3_bus_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == HS_BUS) |-> (cnt_q <= BUS_LAST));

    // R3: the core phase makes no progress without a tick.
    a_r3_core_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == HS_CORE && !core_tick && !abort) |=>
            (phase_q == HS_CORE && $stable(cnt_q)));

endmodule

// File: rtl/rsc_reg_decode.sv
// Module: register decode for the run-state controller. It turns bus writes
// into action strobes and builds the read word.
// Assumes: byte offsets are word-aligned and distinct.
module rsc_reg_decode
    import rsc_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int OFS_STATE = 0,
    parameter int OFS_SRST  = 8,
    parameter int OFS_ERR   = 12
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  run_state_e        cur_state,
    input  logic              valid,
    input  logic              ready,
    input  logic              busy_err,
    input  logic              bus_err,
    output logic              wr_state,
    output run_state_e        wr_code,
    output logic              wr_srst,
    output logic              wr_errclr,
    output logic [31:0]       reg_rdata
);

    localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(OFS_STATE);
    localparam logic [ADDR_W-1:0] A_SRST  = ADDR_W'(OFS_SRST);
    localparam logic [ADDR_W-1:0] A_ERR   = ADDR_W'(OFS_ERR);

    // Purpose: decode writes into action strobes.
    always_comb begin
        wr_state  = reg_wr && (reg_addr == A_STATE);
        wr_code   = run_state_e'(reg_wdata[1:0]);
        wr_srst   = reg_wr && (reg_addr == A_SRST) && reg_wdata[0];
        wr_errclr = reg_wr && (reg_addr == A_ERR) && reg_wdata[ERR_BUSY_BIT];
    end

    // Purpose: build the read word for the addressed register.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STATE) begin
            reg_rdata[1:0]       = cur_state;
            reg_rdata[VALID_BIT] = valid;
            reg_rdata[READY_BIT] = ready;
        end else if (reg_addr == A_ERR) begin
            reg_rdata[ERR_BUSY_BIT] = busy_err;
            reg_rdata[ERR_BUS_BIT]  = bus_err;
        end
    end

endmodule

// File: rtl/runstate_ctrl.sv
// Module: top of the handshaked run-state controller. It holds the committed
// state, starts the handshake on accepted writes, and keeps the busy-write
// and bus-error flags.
// Assumes: the core clock is represented by core_tick in the bus clock domain.
module runstate_ctrl
    import rsc_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int OFS_STATE  = 0,
    parameter int OFS_SRST   = 8,
    parameter int OFS_ERR    = 12,
    parameter int BUS_CYCLES = 3,
    parameter int CORE_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              srst_strobe,
    input  logic              core_tick,
    input  logic              bus_err_evt,
    output logic [1:0]        state_out,
    output logic              state_valid,
    output logic              run_enable,
    output logic              pause_hold,
    output logic              bus_err_irq
);

    run_state_e state_q, target_q, wr_code;
    logic wr_state, wr_srst, wr_errclr;
    logic hs_busy, hs_done;
    logic sreset, hs_start, busy_drop;
    logic busy_err_q, bus_err_q, ready;

    rsc_reg_decode #(
        .ADDR_W(ADDR_W), .OFS_STATE(OFS_STATE),
        .OFS_SRST(OFS_SRST), .OFS_ERR(OFS_ERR)
    ) u_decode (
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cur_state(state_q), .valid(state_valid), .ready(ready),
        .busy_err(busy_err_q), .bus_err(bus_err_q),
        .wr_state(wr_state), .wr_code(wr_code), .wr_srst(wr_srst),
        .wr_errclr(wr_errclr), .reg_rdata(reg_rdata)
    );

    rsc_handshake_timer #(
        .BUS_CYC(BUS_CYCLES), .CORE_TICKS(CORE_TICKS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start(hs_start), .abort(sreset),
        .core_tick(core_tick), .busy(hs_busy), .done(hs_done)
    );

    // Purpose: classify the current write and the soft-reset request.
    always_comb begin
        sreset    = srst_strobe || wr_srst;
        hs_start  = wr_state && !hs_busy && (wr_code != RS_UNUSED) && !sreset;
        busy_drop = wr_state && hs_busy && !sreset;
    end

    // Purpose: committed state; changes only on soft reset or handshake end.
    always_ff @(posedge clk) begin
        if (!rst_n || sreset) state_q <= RS_RESET;
        else if (hs_done)     state_q <= target_q;
    end

    // Purpose: latch the requested state when a handshake starts.
    always_ff @(posedge clk) begin
        if (!rst_n)        target_q <= RS_RESET;
        else if (hs_start) target_q <= wr_code;
    end

    // Purpose: sticky flag for state writes dropped during a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n || sreset) busy_err_q <= 1'b0;
        else if (busy_drop)   busy_err_q <= 1'b1;
        else if (wr_errclr)   busy_err_q <= 1'b0;
    end

    // Purpose: pending bus error; a new event wins over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  bus_err_q <= 1'b0;
        else if (bus_err_evt)                        bus_err_q <= 1'b1;
        else if (sreset)                             bus_err_q <= 1'b0;
        else if (hs_start && wr_code == RS_RESET)    bus_err_q <= 1'b0;
    end

    // Purpose: drive the outputs toward software and the data engine.
    always_comb begin
        state_valid = !hs_busy;
        ready       = state_valid && !bus_err_q;
        state_out   = state_q;
        run_enable  = state_valid && (state_q == RS_RUN);
        pause_hold  = (state_q == RS_PAUSE);
        bus_err_irq = bus_err_q;
    end

    // R2: an accepted write drops valid on the next cycle.
    a_r2_accept_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        hs_start |=> !state_valid);

    // R2: the committed state holds while the handshake runs.
    a_r2_state_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_valid && !sreset) |=> ($stable(state_q) || state_valid));

    // R4: the unused code leaves the state and valid untouched.
    a_r4_unused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state && wr_code == RS_UNUSED && state_valid && !sreset) |=>
            ($stable(state_q) && state_valid));

    // R5: a write during a handshake sets the sticky flag.
    a_r5_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state && !state_valid && !sreset) |=> busy_err_q);

    // R6: soft reset forces the reset state with valid high.
    a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        sreset |=> (state_q == RS_RESET && state_valid));

    // R7: an accepted reset-code write clears a pending bus error.
    a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_start && wr_code == RS_RESET && !bus_err_evt) |=> !bus_err_irq);

endmodule

// File: tb/runstate_ctrl_bench.sv
// Bench: drives the controller and compares it every clock with a
// behavioural countdown model; directed checks add exact-timing points.
module runstate_ctrl_bench;

    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        srst_strobe = 1'b0;
    logic        core_tick = 1'b1;
    logic        bus_err_evt = 1'b0;
    logic [1:0]  state_out;
    logic        state_valid, run_enable, pause_hold, bus_err_irq;

    int tests = 0;
    int fails = 0;
    int tick_mode = 0;

    // Reference model state.
    int m_st = 0, m_tgt = 0, m_vl = 1, m_bl = 0, m_tl = 0, m_be = 0, m_bz = 0;

    always #4 clk = ~clk;

    runstate_ctrl u_runstate_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .srst_strobe(srst_strobe),
        .core_tick(core_tick), .bus_err_evt(bus_err_evt), .state_out(state_out),
        .state_valid(state_valid), .run_enable(run_enable),
        .pause_hold(pause_hold), .bus_err_irq(bus_err_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [AW-1:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 4'd0) begin
            r[1:0] = 2'(m_st);
            r[2]   = (m_vl != 0);
            r[4]   = (m_vl != 0) && (m_be == 0);
        end else if (a == 4'd12) begin
            r[0] = (m_bz != 0);
            r[1] = (m_be != 0);
        end
        return r;
    endfunction

    // Tick pattern: 0 always on, 1 every other cycle, 2 off.
    always @(negedge clk) begin
        if (tick_mode == 0)      core_tick <= 1'b1;
        else if (tick_mode == 1) core_tick <= ~core_tick;
        else                     core_tick <= 1'b0;
    end

    // Model update at each edge, then compare shortly after.
    always @(posedge clk) begin
        int old_vl;
        old_vl = m_vl;
        if (!rst_n) begin
            m_st = 0; m_tgt = 0; m_vl = 1; m_bl = 0; m_tl = 0; m_be = 0; m_bz = 0;
        end else if (srst_strobe || (reg_wr && reg_addr == 4'd8 && reg_wdata[0])) begin
            m_st = 0; m_vl = 1; m_bl = 0; m_tl = 0; m_be = 0; m_bz = 0;
            if (bus_err_evt) m_be = 1;
        end else begin
            if (old_vl == 0) begin
                if (m_bl > 0) m_bl--;
                else if (core_tick) begin
                    m_tl--;
                    if (m_tl == 0) begin m_st = m_tgt; m_vl = 1; end
                end
            end
            if (reg_wr && reg_addr == 4'd0) begin
                if (old_vl == 0) m_bz = 1;
                else if (reg_wdata[1:0] != 2'd2) begin
                    m_tgt = int'(reg_wdata[1:0]); m_vl = 0; m_bl = 3; m_tl = 3;
                    if (reg_wdata[1:0] == 2'd0) m_be = 0;
                end
            end
            if (reg_wr && reg_addr == 4'd12 && reg_wdata[0]) m_bz = 0;
            if (bus_err_evt) m_be = 1;
        end
        #2;
        if (rst_n) begin
            chk("R3 state", 32'(state_out), 32'(m_st));
            chk("R2 valid", 32'(state_valid), 32'(m_vl));
            chk("R8 run_enable", 32'(run_enable), 32'((m_vl != 0) && m_st == 1));
            chk("R8 pause_hold", 32'(pause_hold), 32'(m_st == 3));
            chk("R7 irq", 32'(bus_err_irq), 32'(m_be));
            chk("R9 rdata", reg_rdata, model_rd(reg_addr));
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = '0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk("R1 state", 32'(state_out), 0);
        chk("R1 valid", 32'(state_valid), 1);
        chk("R1 run/pause/irq", {run_enable, pause_hold, bus_err_irq}, 0);
        rd(4'd0, r); chk("R1 state reg", r, 32'h14);
        rd(4'd12, r); chk("R1 err reg", r, 0);

        // R2/R3 write run, exact commit edge
        wr(4'd0, 32'd1);
        chk("R2 valid drops", 32'(state_valid), 0);
        chk("R2 state held", 32'(state_out), 0);
        wait_n(5);
        chk("R3 still busy at edge 5", 32'(state_valid), 0);
        wait_n(1);
        chk("R3 committed at edge 6", {30'(state_out), state_valid, run_enable}, {30'd1, 1'b1, 1'b1});

        // R4 unused code
        wr(4'd0, 32'd2);
        chk("R4 valid kept", 32'(state_valid), 1);
        wait_n(8);
        chk("R4 state kept", 32'(state_out), 1);

        // R5 busy write, R8 pause outputs
        wr(4'd0, 32'd3);
        wr(4'd0, 32'd1);
        rd(4'd12, r); chk("R5 busy flag", r, 1);
        wait_n(8);
        chk("R8 pause", {30'(state_out), run_enable, pause_hold}, {30'd3, 1'b0, 1'b1});
        wr(4'd12, 32'd1);
        rd(4'd12, r); chk("R5 flag cleared", r, 0);

        // R3 stall without ticks
        tick_mode = 2;
        wr(4'd0, 32'd1);
        wait_n(20);
        chk("R3 stalled", 32'(state_valid), 0);
        tick_mode = 0;
        wait_n(6);
        chk("R3 resumes", {30'(state_out), state_valid}, {30'd1, 1'b1});

        // R3 sparse ticks
        tick_mode = 1;
        wr(4'd0, 32'd3);
        wait_n(14);
        chk("R3 sparse commit", 32'(state_out), 3);
        tick_mode = 0;

        // R7/R9 bus error
        @(negedge clk); bus_err_evt = 1'b1;
        @(negedge clk); bus_err_evt = 1'b0;
        chk("R7 irq set", 32'(bus_err_irq), 1);
        rd(4'd0, r); chk("R9 ready low", r, 32'h07);
        wr(4'd0, 32'd1);
        wait_n(8);
        chk("R7 run keeps irq", 32'(bus_err_irq), 1);
        wr(4'd0, 32'd0);
        chk("R7 reset write clears", 32'(bus_err_irq), 0);
        wait_n(8);

        // R6 soft reset by register mid-handshake
        wr(4'd0, 32'd1);
        wr(4'd0, 32'd3);
        wr(4'd8, 32'd1);
        chk("R6 reg srst", {30'(state_out), state_valid}, {30'd0, 1'b1});
        rd(4'd12, r); chk("R6 errors cleared", r, 0);
        wait_n(8);
        chk("R6 handshake aborted", 32'(state_out), 0);

        // R6 soft reset by strobe
        wr(4'd0, 32'd3);
        wait_n(8);
        @(negedge clk); srst_strobe = 1'b1;
        @(negedge clk); srst_strobe = 1'b0;
        chk("R6 strobe srst", 32'(state_out), 0);

        // R6 zero write has no effect
        wr(4'd0, 32'd1);
        wait_n(8);
        wr(4'd8, 32'd0);
        wait_n(2);
        chk("R6 zero write ignored", {30'(state_out), state_valid}, {30'd1, 1'b1});

        // R10 unmapped read
        rd(4'd4, r); chk("R10 unmapped", r, 0);

        wait_n(2);
        finish_run();
    end

endmodule